// File: doc/BRIEF.md
# Duobinary Precoder and Three-Level Decoder

This block handles both ends of a link whose channel is shaped on purpose so that each received symbol is the sum of the current transmitted bit and the bit before it. On the transmit side, each incoming data bit is combined by XOR with the last precoded bit the block sent. The result goes out as a binary stream, so the driver swing is the same as for plain NRZ.

On the receive side, the block takes a 2-bit level code for each symbol and recovers the data bit from that symbol alone. It keeps no memory of earlier decisions and has no decision feedback. The precoding is what makes this possible: the middle level always means one data value, and the two outer levels always mean the other.

Each half has its own valid qualifier and adds one register stage of latency. The channel itself exists only in the testbench.

Top module: `dbin_codec`

## Requirements
- R1: While reset is high and on the first cycle after it, tx_valid_o, tx_bit_o, rx_valid_o, rx_data_o and rx_err_o are all 0. The precoder's stored bit starts at 0.
- R2: When tx_valid_i is high, tx_bit_o on the next cycle equals tx_data_i XOR the previous precoded bit. A data 1 toggles the output and a data 0 repeats it.
- R3: When tx_valid_i is low, tx_data_i has no effect: tx_bit_o and the stored precoder bit hold their values.
- R4: tx_valid_o equals tx_valid_i delayed by one cycle.
- R5: A valid rx_level_i of 1 (middle level) gives rx_data_o = 1 on the next cycle.
- R6: A valid rx_level_i of 0 or 2 (outer levels) gives rx_data_o = 0 on the next cycle.
- R7: A valid rx_level_i of 3 is illegal. It raises rx_err_o for one cycle with rx_data_o = 0. Every legal level leaves rx_err_o at 0.
- R8: rx_valid_o equals rx_valid_i delayed by one cycle. When rx_valid_i is low, rx_level_i has no effect: rx_data_o holds its value and rx_err_o is 0 on the next cycle.
- R9: When the precoded stream passes through a channel that adds each bit to the one before it (starting from 0), the receiver recovers every data bit, whatever the previous bit was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_valid_i | input | 1 | Transmit data bit is valid |
| tx_data_i | input | 1 | Transmit data bit |
| tx_valid_o | output | 1 | Precoded bit is valid |
| tx_bit_o | output | 1 | Precoded binary symbol |
| rx_valid_i | input | 1 | Received level is valid |
| rx_level_i | input | 2 | Received level code, 0 to 2 legal and 3 illegal |
| rx_valid_o | output | 1 | Recovered bit is valid |
| rx_data_o | output | 1 | Recovered data bit |
| rx_err_o | output | 1 | Illegal level was received |

## Verification
The embedded assertions check the per-cycle rules on every cycle:
- a data 1 toggles the transmitted bit and a data 0 repeats it;
- idle cycles freeze both halves;
- the valid flags follow their inputs by exactly one cycle;
- each legal level maps to its fixed bit;
- the error flag never appears together with a data 1.

Some behaviour can only be shown by the bench's scenarios. These are the reset values, specific bit patterns against a reference model, and the end-to-end recovery through a behavioural channel that sums adjacent bits. That last check is what proves the receiver needs no knowledge of the previous bit.

// File: rtl/dbin_pkg.sv
package dbin_pkg;

    localparam int LEVEL_W = 2;

    typedef enum logic [LEVEL_W-1:0] {
        LVL_LOW  = 2'd0,
        LVL_MID  = 2'd1,
        LVL_HIGH = 2'd2,
        LVL_BAD  = 2'd3
    } level_e;

    typedef struct packed {
        logic valid;
        logic bit_v;
    } tx_sym_t;

    typedef struct packed {
        logic valid;
        logic data;
        logic err;
    } rx_dec_t;

    // The middle level means the data bit differed from the previous one
    // after precoding, which is exactly a data 1.
    function automatic rx_dec_t slice_level(input level_e lvl);
        rx_dec_t r;
        r.valid = 1'b1;
        unique case (lvl)
            LVL_MID: begin r.data = 1'b1; r.err = 1'b0; end
            LVL_BAD: begin r.data = 1'b0; r.err = 1'b1; end
            default: begin r.data = 1'b0; r.err = 1'b0; end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dbin_precoder.sv
module dbin_precoder
    import dbin_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_data,
    output logic out_valid,
    output logic out_bit
);
    tx_sym_t sym_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sym_q <= '0;
        end else begin
            sym_q.valid <= in_valid;
            if (in_valid)
                sym_q.bit_v <= in_data ^ sym_q.bit_v;
        end
    end

    assign out_valid = sym_q.valid;
    assign out_bit   = sym_q.bit_v;

    // R2: a data 1 toggles the line, a data 0 repeats it
    a_r2_toggle_on_one: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_data) |=> (out_bit != $past(out_bit)));
    a_r2_repeat_on_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_data) |=> $stable(out_bit));
    // R3: idle cycles leave the state alone
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_bit));
    // R4: valid delayed by one cycle
    a_r4_valid_delay: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r4_invalid_delay: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

endmodule

// File: rtl/dbin_slicer.sv
module dbin_slicer
    import dbin_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [LEVEL_W-1:0] in_level,
    output logic               out_valid,
    output logic               out_data,
    output logic               out_err
);
    rx_dec_t dec_d;
    rx_dec_t dec_q;

    always_comb begin
        dec_d = slice_level(level_e'(in_level));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q <= '0;
        end else begin
            dec_q.valid <= in_valid;
            if (in_valid) begin
                dec_q.data <= dec_d.data;
                dec_q.err  <= dec_d.err;
            end else begin
                dec_q.err  <= 1'b0;
            end
        end
    end

    assign out_valid = dec_q.valid;
    assign out_data  = dec_q.data;
    assign out_err   = dec_q.err;

    // R5: middle level gives a one
    a_r5_mid_is_one: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_level == 2'd1) |=> (out_data && !out_err));
    // R6: outer levels give a zero
    a_r6_outer_is_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_level == 2'd0 || in_level == 2'd2)) |=> (!out_data && !out_err));
    // R7: error flag only on code 3 and never with a data 1
    a_r7_bad_flags: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_level == 2'd3) |=> out_err);
    a_r7_err_no_data: assert property (@(posedge clk) disable iff (rst)
        out_err |-> !out_data);
    // R8: idle cycles hold data and clear the error
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_data) && !out_err && !out_valid));

endmodule

// File: rtl/dbin_codec.sv
module dbin_codec
    import dbin_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tx_valid_i,
    input  logic       tx_data_i,
    output logic       tx_valid_o,
    output logic       tx_bit_o,
    input  logic       rx_valid_i,
    input  logic [1:0] rx_level_i,
    output logic       rx_valid_o,
    output logic       rx_data_o,
    output logic       rx_err_o
);
    dbin_precoder u_tx (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (tx_valid_i),
        .in_data   (tx_data_i),
        .out_valid (tx_valid_o),
        .out_bit   (tx_bit_o)
    );

    dbin_slicer u_rx (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (rx_valid_i),
        .in_level  (rx_level_i),
        .out_valid (rx_valid_o),
        .out_data  (rx_data_o),
        .out_err   (rx_err_o)
    );

    // R1: the first cycle out of reset shows cleared outputs
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (!tx_valid_o && !tx_bit_o && !rx_valid_o && !rx_data_o && !rx_err_o));

endmodule

// File: tb/dbin_codec_test.sv
`timescale 1ns/1ps
module dbin_codec_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_valid_i = 1'b0;
    logic       tx_data_i = 1'b0;
    logic       tx_valid_o;
    logic       tx_bit_o;
    logic       rx_valid_i = 1'b0;
    logic [1:0] rx_level_i = 2'd0;
    logic       rx_valid_o;
    logic       rx_data_o;
    logic       rx_err_o;

    int n_checks = 0;
    int n_fail = 0;
    logic model_prev;

    always #2.5 clk = ~clk;

    dbin_codec uut (
        .clk(clk), .rst(rst),
        .tx_valid_i(tx_valid_i), .tx_data_i(tx_data_i),
        .tx_valid_o(tx_valid_o), .tx_bit_o(tx_bit_o),
        .rx_valid_i(rx_valid_i), .rx_level_i(rx_level_i),
        .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o), .rx_err_o(rx_err_o)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic step;
        @(posedge clk); #1;
    endtask

    task automatic do_reset;
        @(negedge clk); rst = 1'b1; tx_valid_i = 0; rx_valid_i = 0;
        step();
        @(negedge clk); rst = 1'b0;
        model_prev = 1'b0;
    endtask

    task automatic t_reset;
        do_reset();
        step();
        check("R1 tx_valid", {7'd0, tx_valid_o}, 8'd0);
        check("R1 tx_bit", {7'd0, tx_bit_o}, 8'd0);
        check("R1 rx_valid", {7'd0, rx_valid_o}, 8'd0);
        check("R1 rx_data", {7'd0, rx_data_o}, 8'd0);
        check("R1 rx_err", {7'd0, rx_err_o}, 8'd0);
    endtask

    task automatic send_tx(input logic d);
        @(negedge clk); tx_valid_i = 1'b1; tx_data_i = d;
        step();
        model_prev = model_prev ^ d;
        check("R2 precoded bit", {7'd0, tx_bit_o}, {7'd0, model_prev});
        check("R4 tx_valid high", {7'd0, tx_valid_o}, 8'd1);
    endtask

    task automatic t_precode;
        logic [15:0] pat = 16'b1011_0010_1110_0001;
        do_reset();
        for (int i = 0; i < 16; i++) send_tx(pat[i]);
        for (int i = 0; i < 6; i++) send_tx(1'b1);
        for (int i = 0; i < 4; i++) send_tx(1'b0);
        @(negedge clk); tx_valid_i = 1'b0;
    endtask

    task automatic t_tx_idle;
        do_reset();
        send_tx(1'b1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); tx_valid_i = 1'b0; tx_data_i = 1'b1;
            step();
            check("R3 idle holds bit", {7'd0, tx_bit_o}, 8'd1);
            check("R4 tx_valid low", {7'd0, tx_valid_o}, 8'd0);
        end
        send_tx(1'b1);
        check("R3 state kept across idle", {7'd0, tx_bit_o}, 8'd0);
        @(negedge clk); tx_valid_i = 1'b0;
    endtask

    task automatic send_rx(input logic [1:0] lvl, input logic exp_d, input logic exp_e, input string req);
        @(negedge clk); rx_valid_i = 1'b1; rx_level_i = lvl;
        step();
        check(req, {6'd0, rx_data_o, rx_err_o}, {6'd0, exp_d, exp_e});
        check("R8 rx_valid high", {7'd0, rx_valid_o}, 8'd1);
    endtask

    task automatic t_levels;
        do_reset();
        send_rx(2'd1, 1'b1, 1'b0, "R5 mid level");
        send_rx(2'd0, 1'b0, 1'b0, "R6 low level");
        send_rx(2'd1, 1'b1, 1'b0, "R5 mid again");
        send_rx(2'd2, 1'b0, 1'b0, "R6 high level");
        send_rx(2'd3, 1'b0, 1'b1, "R7 illegal level");
        send_rx(2'd1, 1'b1, 1'b0, "R7 error clears on legal");
        @(negedge clk); rx_valid_i = 1'b0;
    endtask

    task automatic t_rx_idle;
        do_reset();
        send_rx(2'd1, 1'b1, 1'b0, "R5 before idle");
        @(negedge clk); rx_valid_i = 1'b0; rx_level_i = 2'd0;
        step();
        check("R8 idle data hold", {7'd0, rx_data_o}, 8'd1);
        check("R8 idle valid low", {7'd0, rx_valid_o}, 8'd0);
        send_rx(2'd3, 1'b0, 1'b1, "R7 illegal before idle");
        @(negedge clk); rx_valid_i = 1'b0; rx_level_i = 2'd1;
        step();
        check("R8 idle clears err", {7'd0, rx_err_o}, 8'd0);
        check("R8 idle ignores level", {7'd0, rx_data_o}, 8'd0);
    endtask

    task automatic t_loopback;
        logic [31:0] pat = 32'hC3A5_19E7;
        logic chan_prev = 1'b0;
        logic [1:0] lvl;
        do_reset();
        for (int i = 0; i < 32; i++) begin
            @(negedge clk); tx_valid_i = 1'b1; tx_data_i = pat[i];
            step();
            lvl = {1'b0, tx_bit_o} + {1'b0, chan_prev};
            chan_prev = tx_bit_o;
            @(negedge clk); tx_valid_i = 1'b0; rx_valid_i = 1'b1; rx_level_i = lvl;
            step();
            check("R9 end-to-end bit", {7'd0, rx_data_o}, {7'd0, pat[i]});
            @(negedge clk); rx_valid_i = 1'b0;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_precode();
        t_tx_idle();
        t_levels();
        t_rx_idle();
        t_loopback();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule